// File: doc/BRIEF.md
# Output Denormalize and Clamp Stage

This stage sits after a colour matrix and turns three normalized colour components into integer codes of a chosen output depth. Each component arrives as a signed fixed-point number in which 1.0 stands for full scale. For the scaled depths the value is multiplied by (2^n - 1)/2^n of the code space, i.e. the code is round(v * (2^n - 1)), so that 1.0 lands exactly on the largest code rather than one past it. The product is formed by a shift and a subtract, with no general multiplier.

A two-bit depth mode picks 8, 10 or 12 bits of scaled output, or a plain truncating pass of the upper bits. A separate narrow-bus flag, independent of the mode, limits the output bus to 10 significant bits. Codes are right-aligned on the bus, and when the chosen depth is wider than the bus, the low bits beyond the bus are dropped. Results are registered once; a valid bit travels alongside the data unchanged.

Top module: `denorm_clamp`

## Requirements
- R1: With mode = 1 each output equals round(x * 255 / 2^FRAC_W), clamped to [0, 255], in bits 7:0 with the bits above zero; rounding adds one half and floors.
- R2: With mode = 2 each output equals round(x * 1023 / 2^FRAC_W), clamped to [0, 1023].
- R3: With mode = 3 each output equals round(x * 4095 / 2^FRAC_W), clamped to [0, 4095]; with the narrow flag set the result is shifted right by two.
- R4: With mode = 0 each output equals floor(x / 2^(FRAC_W - W)) clamped to [0, 2^W - 1], where W is 10 when the narrow flag is set and OUT_W otherwise; no scaling is applied.
- R5: A negative input gives code 0 and an input above full scale gives the largest code of the selected depth and bus, in every mode.
- R6: An input of exactly 1.0 (x = 2^FRAC_W) gives exactly 255, 1023 or 4095 in modes 1, 2 and 3 with the narrow flag clear.
- R7: With the narrow flag set no output bit at or above bit 10 is ever 1; modes 1 and 2 give the same codes as with the flag clear.
- R8: Outputs appear one clock after the inputs, the output valid equals the input valid of the previous clock, and during reset all outputs are 0.
- R9: The three components are transformed by the same rule, each from its own input only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Input components are valid |
| depthMode | input | 2 | 0 truncate, 1 8-bit, 2 10-bit, 3 12-bit scaled |
| narrowBus | input | 1 | Limit output bus to 10 bits |
| inC0 | input | IN_W | Component 0, signed, FRAC_W fraction bits |
| inC1 | input | IN_W | Component 1, signed, FRAC_W fraction bits |
| inC2 | input | IN_W | Component 2, signed, FRAC_W fraction bits |
| validOut | output | 1 | Output codes are valid |
| outC0 | output | OUT_W | Component 0 code |
| outC1 | output | OUT_W | Component 1 code |
| outC2 | output | OUT_W | Component 2 code |

## Verification
Clamping and low-bit dropping fall in the same cycle when the 12-bit mode runs with the narrow flag set and an input lies at or above full scale: the clamp must first pin the result to 4095 and the shift must then give 1023, not a wrapped or unclamped value. The bench provokes this by sweeping every input from just below zero to beyond 1.0 under each mode and both flag settings, while the other two lanes carry a reversed ramp and a steeper ramp that reaches far into the clamped region. Each code is judged against an integer formula computed in the bench from the requirement.

// File: rtl/denorm_pkg.sv
package denorm_pkg;

  // Number of scaled depths (8, 10 and 12 bits)
  localparam int DEPTH_COUNT = 3;
  localparam int MAX_DEPTH   = 12;

  function automatic int depthOf(input int idx);
    return 8 + 2 * idx;
  endfunction

  // Strobes from control to datapath
  typedef struct packed {
    logic [DEPTH_COUNT-1:0] scaleSel;  // one-hot scaled depth
    logic                   truncOn;   // plain truncation path
    logic                   narrowOn;  // narrow output bus
    logic [1:0]             dropBits;  // low bits dropped after clamp
  } dnCtrl_t;

endpackage

// File: rtl/denorm_ctrl.sv
module denorm_ctrl
  import denorm_pkg::*;
#(
  parameter int OUT_W    = 12,
  parameter int NARROW_W = 10
) (
  input  logic [1:0] depthMode,
  input  logic       narrowBus,
  output dnCtrl_t    ctrl
);

  always_comb begin
    int depthN;
    int busW;
    ctrl          = '0;
    ctrl.narrowOn = narrowBus;
    busW          = narrowBus ? NARROW_W : OUT_W;
    depthN        = 6 + 2 * int'(depthMode);
    if (depthMode == 2'd0) begin
      ctrl.truncOn = 1'b1;
    end else begin
      ctrl.scaleSel[int'(depthMode) - 1] = 1'b1;
      if (depthN > busW) ctrl.dropBits = 2'(depthN - busW);
    end
  end

endmodule

// File: rtl/denorm_lane.sv
module denorm_lane
  import denorm_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int FRAC_W   = 12,
  parameter int OUT_W    = 12,
  parameter int NARROW_W = 10
) (
  input  logic [IN_W-1:0]  inVal,
  input  dnCtrl_t          ctrl,
  output logic [OUT_W-1:0] code
);

  localparam int PW = IN_W + MAX_DEPTH + 2;
  localparam logic signed [PW-1:0] HALF = PW'(2 ** (FRAC_W - 1));

  logic signed [PW-1:0] xExt;
  assign xExt = PW'($signed(inVal));

  logic [DEPTH_COUNT-1:0][OUT_W-1:0] scaled;
  logic [1:0][OUT_W-1:0]             truncd;

  // Scaled paths: round(x * (2^n - 1) / 2^FRAC_W) via shift and subtract
  for (genvar d = 0; d < DEPTH_COUNT; d++) begin : g_depth
    localparam int N = depthOf(d);
    localparam logic signed [PW-1:0] MAXV = PW'(2 ** N - 1);
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    assign prod = (xExt <<< N) - xExt;
    assign rnd  = (prod + HALF) >>> FRAC_W;
    always_comb begin
      if (rnd[PW-1])      scaled[d] = '0;
      else if (rnd > MAXV) scaled[d] = OUT_W'(MAXV);
      else                 scaled[d] = rnd[OUT_W-1:0];
    end
  end

  // Truncating paths: index 0 narrow bus, index 1 full bus
  for (genvar b = 0; b < 2; b++) begin : g_trunc
    localparam int BW = (b == 0) ? NARROW_W : OUT_W;
    localparam logic signed [PW-1:0] MAXT = PW'(2 ** BW - 1);
    logic signed [PW-1:0] tr;
    assign tr = xExt >>> (FRAC_W - BW);
    always_comb begin
      if (tr[PW-1])       truncd[b] = '0;
      else if (tr > MAXT) truncd[b] = OUT_W'(MAXT);
      else                truncd[b] = tr[OUT_W-1:0];
    end
  end

  always_comb begin
    logic [OUT_W-1:0] pick;
    pick = '0;
    for (int d = 0; d < DEPTH_COUNT; d++)
      if (ctrl.scaleSel[d]) pick = pick | scaled[d];
    if (ctrl.truncOn) pick = ctrl.narrowOn ? truncd[0] : truncd[1];
    code = pick >> ctrl.dropBits;
  end

endmodule

// File: rtl/denorm_datapath.sv
module denorm_datapath
  import denorm_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int FRAC_W   = 12,
  parameter int OUT_W    = 12,
  parameter int NARROW_W = 10,
  parameter int LANES    = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       validIn,
  input  dnCtrl_t                    ctrl,
  input  logic [LANES-1:0][IN_W-1:0] inVec,
  output logic                       validOut,
  output logic [LANES-1:0][OUT_W-1:0] outVec
);

  logic [LANES-1:0][OUT_W-1:0] laneCode;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    denorm_lane #(
      .IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .NARROW_W(NARROW_W)
    ) u_lane (
      .inVal(inVec[l]),
      .ctrl (ctrl),
      .code (laneCode[l])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut <= 1'b0;
      outVec   <= '0;
    end else begin
      validOut <= validIn;
      outVec   <= laneCode;
    end
  end

endmodule

// File: rtl/denorm_clamp.sv
module denorm_clamp
  import denorm_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int FRAC_W   = 12,
  parameter int OUT_W    = 12,
  parameter int NARROW_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [1:0]       depthMode,
  input  logic             narrowBus,
  input  logic [IN_W-1:0]  inC0,
  input  logic [IN_W-1:0]  inC1,
  input  logic [IN_W-1:0]  inC2,
  output logic             validOut,
  output logic [OUT_W-1:0] outC0,
  output logic [OUT_W-1:0] outC1,
  output logic [OUT_W-1:0] outC2
);

  localparam int LANES = 3;

  dnCtrl_t                     ctrl;
  logic [LANES-1:0][IN_W-1:0]  inVec;
  logic [LANES-1:0][OUT_W-1:0] outVec;

  assign inVec = {inC2, inC1, inC0};

  denorm_ctrl #(.OUT_W(OUT_W), .NARROW_W(NARROW_W)) u_ctrl (
    .depthMode(depthMode),
    .narrowBus(narrowBus),
    .ctrl     (ctrl)
  );

  denorm_datapath #(
    .IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W),
    .NARROW_W(NARROW_W), .LANES(LANES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .ctrl    (ctrl),
    .inVec   (inVec),
    .validOut(validOut),
    .outVec  (outVec)
  );

  assign outC0 = outVec[0];
  assign outC1 = outVec[1];
  assign outC2 = outVec[2];

endmodule

// File: rtl/denorm_clamp_chk.sv
module denorm_clamp_chk #(
  parameter int IN_W     = 16,
  parameter int FRAC_W   = 12,
  parameter int OUT_W    = 12,
  parameter int NARROW_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             validIn,
  input logic [1:0]       depthMode,
  input logic             narrowBus,
  input logic [IN_W-1:0]  inC0,
  input logic [OUT_W-1:0] outC0,
  input logic [OUT_W-1:0] outC1,
  input logic [OUT_W-1:0] outC2,
  input logic             validOut
);

  localparam logic [IN_W-1:0] ONE = IN_W'(2 ** FRAC_W);

  // R8
  valid_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> validOut == $past(validIn));

  // R5
  neg_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    inC0[IN_W-1] |=> outC0 == '0);

  // R6
  full8_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inC0 == ONE && depthMode == 2'd1) |=> outC0 == OUT_W'(255));

  // R6
  full12_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inC0 == ONE && depthMode == 2'd3 && !narrowBus) |=> outC0 == OUT_W'(4095));

  // R7
  narrow_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(narrowBus)) |->
      ((outC0 >> NARROW_W) == '0 && (outC1 >> NARROW_W) == '0 && (outC2 >> NARROW_W) == '0));

  // R1
  range8_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(depthMode) == 2'd1) |-> (outC0 >> 8) == '0);

endmodule

bind denorm_clamp denorm_clamp_chk #(
  .IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .NARROW_W(NARROW_W)
) u_chk (
  .clk(clk), .rstN(rstN), .validIn(validIn), .depthMode(depthMode),
  .narrowBus(narrowBus), .inC0(inC0), .outC0(outC0), .outC1(outC1),
  .outC2(outC2), .validOut(validOut)
);

// File: tb/denorm_clamp_tb.sv
module denorm_clamp_tb;

  localparam int IN_W = 16, FRAC_W = 12, OUT_W = 12, NARROW_W = 10;
  localparam int ONE = 2 ** FRAC_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0;
  logic [1:0] depthMode = 2'd0;
  logic narrowBus = 1'b0;
  logic [IN_W-1:0] inC0 = '0, inC1 = '0, inC2 = '0;
  logic validOut;
  logic [OUT_W-1:0] outC0, outC1, outC2;

  int compared = 0, mismatched = 0;
  bit havePrev = 0;
  int expV[3];
  int inPrev[3];
  int modePrev;
  bit nbPrev;
  bit validPrev;

  always #10 clk = ~clk;

  denorm_clamp #(.IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .NARROW_W(NARROW_W)) u_dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .depthMode(depthMode),
    .narrowBus(narrowBus), .inC0(inC0), .inC1(inC1), .inC2(inC2),
    .validOut(validOut), .outC0(outC0), .outC1(outC1), .outC2(outC2)
  );

  function automatic int model(int x, int m, bit nb);
    int busW, n, c, mx;
    busW = nb ? NARROW_W : OUT_W;
    if (m == 0) begin
      c  = x >>> (FRAC_W - busW);
      mx = 2 ** busW - 1;
    end else begin
      n  = 6 + 2 * m;
      mx = 2 ** n - 1;
      c  = (x * mx + ONE / 2) >>> FRAC_W;
    end
    if (c < 0) c = 0;
    if (c > mx) c = mx;
    if (m != 0 && 6 + 2 * m > busW) c = c >> (6 + 2 * m - busW);
    return c;
  endfunction

  function automatic string tagOf(int x, int m, bit nb, int lane);
    if (x < 0 || x > ONE) return "R5";
    if (x == ONE && m != 0 && !nb) return "R6";
    if (lane != 0) return "R9";
    if (nb) return "R7";
    case (m)
      0: return "R4";
      1: return "R1";
      2: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareOut();
    int act[3];
    act[0] = int'(outC0); act[1] = int'(outC1); act[2] = int'(outC2);
    check("R8", int'(validOut), int'(validPrev), "valid forward");
    for (int l = 0; l < 3; l++)
      check(tagOf(inPrev[l], modePrev, nbPrev, l), act[l], expV[l],
            $sformatf("lane%0d x=%0d mode=%0d nb=%0d", l, inPrev[l], modePrev, nbPrev));
  endtask

  task automatic drive(bit v, int m, bit nb, int a, int b, int c);
    @(negedge clk);
    if (havePrev) compareOut();
    validIn = v; depthMode = 2'(m); narrowBus = nb;
    inC0 = IN_W'(a); inC1 = IN_W'(b); inC2 = IN_W'(c);
    inPrev[0] = a; inPrev[1] = b; inPrev[2] = c;
    for (int l = 0; l < 3; l++) expV[l] = model(inPrev[l], m, nb);
    modePrev = m; nbPrev = nb; validPrev = v; havePrev = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    validIn = 1'b1; inC0 = IN_W'(ONE); inC1 = IN_W'(ONE); inC2 = IN_W'(ONE);
    depthMode = 2'd3;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", int'(validOut), 0, "reset valid");
    check("R8", int'(outC0) + int'(outC1) + int'(outC2), 0, "reset data");
    validIn = 1'b0;
    rstN = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int nb = 0; nb < 2; nb++) begin
        for (int x = -64; x <= ONE + 64; x++)
          drive((x % 7) != 0, m, nb[0], x, ONE - x, 3 * x - 2000);
        // R5: extreme inputs
        drive(1'b1, m, nb[0], 32767, -32768, ONE + 1);
        drive(1'b1, m, nb[0], -1, ONE - 1, ONE / 2);
      end
    @(negedge clk);
    compareOut();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule